// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block watches a processor's instruction fetch stream and its data access stream and raises debug events when an address matches one of its programmed slots. It holds `N_BP` instruction-breakpoint slots and `N_WP` data-watchpoint slots. Each slot is a pair of registers: a value register holding an aligned address and a control register holding an arm bit, a privilege filter, an access-direction filter, an 8-bit byte-lane mask and, for breakpoints, an inverted-match flag. Slots are loaded through a single-cycle register-write port.

Every cycle the block compares the current fetch address against all breakpoint slots and the current data access against all watchpoint slots. It registers a per-slot hit vector for each kind and issues at most one event per cycle, tagged with a type code. When both kinds hit in the same cycle, the breakpoint event is issued first and the watchpoint event follows one cycle later. Breakpoint slots set to inverted-match fire on every fetch that misses the programmed location, which lets a debugger stop after exactly one instruction. A constant identity word tells software how many slots of each kind exist.

Top module: `dbg_match_bank`

## Requirements
- R1: After a synchronous reset every value and control register is zero, so no slot fires until it is programmed, and all outputs read zero.
- R2: A slot takes part in matching only while bit 0 (arm) of its control register is 1; writing 0 to the control register disarms it.
- R3: A breakpoint matches when its value register equals the fetch address with bits 1:0 cleared and the byte-lane mask bit selected by fetch address bits 1:0 is set; the mask occupies control bits 12:5, with mask bit k at control bit 5+k.
- R4: A breakpoint with control bit 13 (inverted-match) set fires on a valid fetch exactly when the R3 match is false.
- R5: A watchpoint whose mask has any of bits 7:4 set works on doublewords: it compares against the data address with bits 2:0 cleared and selects the mask bit with address bits 2:0; otherwise it clears bits 1:0 and selects with bits 1:0.
- R6: A watchpoint fires on a read only if control bit 3 (load) is set and on a write only if control bit 4 (store) is set.
- R7: A slot fires on a privileged access only if control bit 1 is set and on an unprivileged access only if control bit 2 is set.
- R8: `evt_valid` pulses with `evt_code` 1 (breakpoint) in the cycle breakpoint hits are shown; a watchpoint hit gives code 2; when both kinds hit together the code-2 event is held and issued in the next cycle; `evt_code` is 0 when no event.
- R9: Hit vectors and events appear in the cycle after the access is presented; a register write affects comparisons from the next cycle on, so an access presented in the same cycle as the write uses the old settings.
- R10: `id_word` carries watchpoint count minus one in bits 31:28, breakpoint count minus one in bits 27:24, and zero elsewhere.
- R11: With `fetch_valid` low no breakpoint fires, inverted-match slots included; with `data_valid` low no watchpoint fires.
- R12: A write whose slot index is not below the slot count of the selected kind changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Target: 0 breakpoint value, 1 breakpoint control, 2 watchpoint value, 3 watchpoint control |
| wr_idx | input | 4 | Slot index |
| wr_data | input | AW | Write data (control uses bits 13:0) |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | AW | Instruction fetch address |
| fetch_priv | input | 1 | Fetch is privileged |
| data_valid | input | 1 | Data access valid |
| data_addr | input | AW | Data access address |
| data_write | input | 1 | 1 write, 0 read |
| data_priv | input | 1 | Data access is privileged |
| bp_hit | output | N_BP | Registered breakpoint hit per slot |
| wp_hit | output | N_WP | Registered watchpoint hit per slot |
| evt_valid | output | 1 | Event pulse |
| evt_code | output | 2 | Event type: 1 breakpoint, 2 watchpoint |
| id_word | output | 32 | Slot count identity word |

## Verification
Directed fetches step through every lane of a halfword-wide breakpoint so a wrong lane index or a missing alignment mask shows as a hit on the wrong offset. A doubleword watchpoint whose mask covers only the upper word is hit at base+4, which separates the 3-bit from the 2-bit alignment path, and read/write and privileged/user accesses are driven against one-sided filters. Simultaneous breakpoint and watchpoint hits, writes coinciding with accesses, and out-of-range indices check ordering and timing, while randomized configurations with addresses drawn near the programmed values exercise all fields together against a bench model.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int CTL_W    = 14;
  localparam int CB_ARM   = 0;
  localparam int CB_PRIV  = 1;
  localparam int CB_USER  = 2;
  localparam int CB_LOAD  = 3;
  localparam int CB_STORE = 4;
  localparam int CB_BS_LO = 5;
  localparam int CB_MISM  = 13;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_BP   = 2'd1,
    EV_WP   = 2'd2
  } evt_e;

  typedef enum logic [1:0] {
    WK_BPV = 2'd0,
    WK_BPC = 2'd1,
    WK_WPV = 2'd2,
    WK_WPC = 2'd3
  } wkind_e;

  function automatic logic priv_ok(input logic [CTL_W-1:0] c, input logic p);
    return p ? c[CB_PRIV] : c[CB_USER];
  endfunction
endpackage

// File: rtl/dbgm_slot_regs.sv
module dbgm_slot_regs #(
  parameter int COUNT = 4,
  parameter int AW    = 32,
  parameter int CW    = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_val,
  input  logic                       we_ctl,
  input  logic [3:0]                 idx,
  input  logic [AW-1:0]              wdata,
  output logic [COUNT-1:0][AW-1:0]   val_q,
  output logic [COUNT-1:0][CW-1:0]   ctl_q
);
  for (genvar g = 0; g < COUNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[g] <= '0;
        ctl_q[g] <= '0;
      end else begin
        if (we_val && idx == 4'(g)) val_q[g] <= wdata;
        if (we_ctl && idx == 4'(g)) ctl_q[g] <= wdata[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/dbgm_bp_match.sv
module dbgm_bp_match
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    val,
  input  logic [CTL_W-1:0] ctl,
  input  logic             valid,
  input  logic [AW-1:0]    addr,
  input  logic             priv,
  output logic             hit
);
  logic       same;
  logic [7:0] lanes;
  logic       unused_bits;

  assign unused_bits = ^{ctl[CB_LOAD], ctl[CB_STORE]};
  assign lanes = ctl[CB_BS_LO +: 8];
  assign same  = (val == {addr[AW-1:2], 2'b00}) && lanes[{1'b0, addr[1:0]}];

  always_comb begin
    hit = valid && ctl[CB_ARM] && priv_ok(ctl, priv);
    if (ctl[CB_MISM]) hit = hit && !same;
    else              hit = hit && same;
  end
endmodule

// File: rtl/dbgm_wp_match.sv
module dbgm_wp_match
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    val,
  input  logic [CTL_W-1:0] ctl,
  input  logic             valid,
  input  logic [AW-1:0]    addr,
  input  logic             write,
  input  logic             priv,
  output logic             hit
);
  logic          wide;
  logic [7:0]    lanes;
  logic [AW-1:0] low_mask;
  logic [2:0]    lane_sel;
  logic          dir_ok;
  logic          unused_bits;

  assign unused_bits = ctl[CB_MISM];
  assign lanes    = ctl[CB_BS_LO +: 8];
  assign wide     = |lanes[7:4];
  assign low_mask = {{(AW-3){1'b0}}, wide, 2'b11};
  assign lane_sel = wide ? addr[2:0] : {1'b0, addr[1:0]};
  assign dir_ok   = write ? ctl[CB_STORE] : ctl[CB_LOAD];
  assign hit = valid && ctl[CB_ARM] && priv_ok(ctl, priv) && dir_ok &&
               (val == (addr & ~low_mask)) && lanes[lane_sel];
endmodule

// File: rtl/dbgm_evt_arb.sv
module dbgm_evt_arb
  import dbgm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bp_any,
  input  logic wp_any,
  output logic evt_valid,
  output logic [1:0] evt_code
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      evt_valid <= 1'b0;
      evt_code  <= EV_NONE;
    end else if (bp_any) begin
      pend_q    <= pend_q | wp_any;
      evt_valid <= 1'b1;
      evt_code  <= EV_BP;
    end else if (pend_q || wp_any) begin
      pend_q    <= 1'b0;
      evt_valid <= 1'b1;
      evt_code  <= EV_WP;
    end else begin
      evt_valid <= 1'b0;
      evt_code  <= EV_NONE;
    end
  end
endmodule

// File: rtl/dbg_match_bank.sv
module dbg_match_bank
  import dbgm_pkg::*;
#(
  parameter int N_BP = 4,
  parameter int N_WP = 2,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_kind,
  input  logic [3:0]      wr_idx,
  input  logic [AW-1:0]   wr_data,
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  input  logic            fetch_priv,
  input  logic            data_valid,
  input  logic [AW-1:0]   data_addr,
  input  logic            data_write,
  input  logic            data_priv,
  output logic [N_BP-1:0] bp_hit,
  output logic [N_WP-1:0] wp_hit,
  output logic            evt_valid,
  output logic [1:0]      evt_code,
  output logic [31:0]     id_word
);
  logic [N_BP-1:0][AW-1:0]    bp_val;
  logic [N_BP-1:0][CTL_W-1:0] bp_ctl;
  logic [N_WP-1:0][AW-1:0]    wp_val;
  logic [N_WP-1:0][CTL_W-1:0] wp_ctl;
  logic [N_BP-1:0]            bp_c;
  logic [N_WP-1:0]            wp_c;

  assign id_word = {4'(N_WP - 1), 4'(N_BP - 1), 24'h0};

  dbgm_slot_regs #(.COUNT(N_BP), .AW(AW), .CW(CTL_W)) u_bp_regs (
    .clk(clk), .rst(rst),
    .we_val(wr_en && wr_kind == WK_BPV),
    .we_ctl(wr_en && wr_kind == WK_BPC),
    .idx(wr_idx), .wdata(wr_data),
    .val_q(bp_val), .ctl_q(bp_ctl)
  );

  dbgm_slot_regs #(.COUNT(N_WP), .AW(AW), .CW(CTL_W)) u_wp_regs (
    .clk(clk), .rst(rst),
    .we_val(wr_en && wr_kind == WK_WPV),
    .we_ctl(wr_en && wr_kind == WK_WPC),
    .idx(wr_idx), .wdata(wr_data),
    .val_q(wp_val), .ctl_q(wp_ctl)
  );

  for (genvar i = 0; i < N_BP; i++) begin : g_bp
    dbgm_bp_match #(.AW(AW)) u_cmp (
      .val(bp_val[i]), .ctl(bp_ctl[i]), .valid(fetch_valid),
      .addr(fetch_addr), .priv(fetch_priv), .hit(bp_c[i])
    );
  end

  for (genvar j = 0; j < N_WP; j++) begin : g_wp
    dbgm_wp_match #(.AW(AW)) u_cmp (
      .val(wp_val[j]), .ctl(wp_ctl[j]), .valid(data_valid),
      .addr(data_addr), .write(data_write), .priv(data_priv), .hit(wp_c[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_hit <= '0;
      wp_hit <= '0;
    end else begin
      bp_hit <= bp_c;
      wp_hit <= wp_c;
    end
  end

  dbgm_evt_arb u_arb (
    .clk(clk), .rst(rst), .bp_any(|bp_c), .wp_any(|wp_c),
    .evt_valid(evt_valid), .evt_code(evt_code)
  );
endmodule

// File: rtl/dbgm_chk.sv
module dbgm_chk #(
  parameter int N_BP = 4,
  parameter int N_WP = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic            data_valid,
  input logic [N_BP-1:0] bp_hit,
  input logic [N_WP-1:0] wp_hit,
  input logic            evt_valid,
  input logic [1:0]      evt_code
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (bp_hit == '0 && wp_hit == '0 && !evt_valid));
  // R11
  no_fetch_no_bp_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> bp_hit == '0);
  // R11
  no_data_no_wp_chk: assert property (@(posedge clk) disable iff (rst)
    !data_valid |=> wp_hit == '0);
  // R8
  bp_event_chk: assert property (@(posedge clk) disable iff (rst)
    (|bp_hit) |-> (evt_valid && evt_code == 2'd1));
  // R8
  wp_event_chk: assert property (@(posedge clk) disable iff (rst)
    ((|wp_hit) && !(|bp_hit)) |-> (evt_valid && evt_code == 2'd2));
  // R8
  held_wp_chk: assert property (@(posedge clk) disable iff (rst)
    ((|bp_hit) && (|wp_hit)) |=> (evt_valid && ((|bp_hit) ? evt_code == 2'd1 : evt_code == 2'd2)));
  // R8
  code_valid_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid == (evt_code != 2'd0));
endmodule

bind dbg_match_bank dbgm_chk #(.N_BP(N_BP), .N_WP(N_WP)) u_dbgm_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .data_valid(data_valid),
  .bp_hit(bp_hit), .wp_hit(wp_hit), .evt_valid(evt_valid), .evt_code(evt_code)
);

// File: tb/test_dbg_match_bank.sv
module test_dbg_match_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N_BP = 4;
  localparam int N_WP = 2;
  localparam int AW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [3:0] wr_idx = '0;
  logic [AW-1:0] wr_data = '0;
  logic fetch_valid = 1'b0, fetch_priv = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic data_valid = 1'b0, data_write = 1'b0, data_priv = 1'b0;
  logic [AW-1:0] data_addr = '0;
  logic [N_BP-1:0] bp_hit;
  logic [N_WP-1:0] wp_hit;
  logic evt_valid;
  logic [1:0] evt_code;
  logic [31:0] id_word;

  int checks = 0;
  int fails  = 0;

  logic [AW-1:0] m_bpv [N_BP];
  logic [13:0]   m_bpc [N_BP];
  logic [AW-1:0] m_wpv [N_WP];
  logic [13:0]   m_wpc [N_WP];
  logic          m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_bank #(.N_BP(N_BP), .N_WP(N_WP), .AW(AW)) i_dbg_match_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_priv(fetch_priv), .data_valid(data_valid), .data_addr(data_addr),
    .data_write(data_write), .data_priv(data_priv), .bp_hit(bp_hit),
    .wp_hit(wp_hit), .evt_valid(evt_valid), .evt_code(evt_code), .id_word(id_word)
  );

  function automatic logic pok(input logic [13:0] c, input logic p);
    return p ? c[1] : c[2];
  endfunction

  function automatic logic e_bp(input int i, input logic v, input logic [AW-1:0] a, input logic p);
    logic m;
    m = (m_bpv[i] == {a[AW-1:2], 2'b00}) && m_bpc[i][5 + a[1:0]];
    if (!v || !m_bpc[i][0] || !pok(m_bpc[i], p)) return 1'b0;
    return m_bpc[i][13] ? !m : m;
  endfunction

  function automatic logic e_wp(input int j, input logic v, input logic [AW-1:0] a,
                                input logic w, input logic p);
    logic wide;
    logic [2:0] sel;
    logic [AW-1:0] base;
    wide = |m_wpc[j][12:9];
    sel  = wide ? a[2:0] : {1'b0, a[1:0]};
    base = wide ? {a[AW-1:3], 3'b000} : {a[AW-1:2], 2'b00};
    if (!v || !m_wpc[j][0] || !pok(m_wpc[j], p)) return 1'b0;
    if (w ? !m_wpc[j][4] : !m_wpc[j][3]) return 1'b0;
    return (m_wpv[j] == base) && m_wpc[j][5 + sel];
  endfunction

  task automatic step(input logic we, input logic [1:0] kd, input logic [3:0] ix,
                      input logic [AW-1:0] wd, input logic fv, input logic [AW-1:0] fa,
                      input logic fp, input logic dv, input logic [AW-1:0] da,
                      input logic dw, input logic dp, input string tag);
    logic [N_BP-1:0] xb;
    logic [N_WP-1:0] xw;
    logic [1:0] xc;
    @(negedge clk);
    wr_en = we; wr_kind = kd; wr_idx = ix; wr_data = wd;
    fetch_valid = fv; fetch_addr = fa; fetch_priv = fp;
    data_valid = dv; data_addr = da; data_write = dw; data_priv = dp;
    for (int i = 0; i < N_BP; i++) xb[i] = e_bp(i, fv, fa, fp);
    for (int j = 0; j < N_WP; j++) xw[j] = e_wp(j, dv, da, dw, dp);
    if (|xb) begin xc = 2'd1; m_pend = m_pend | (|xw); end
    else if (m_pend || (|xw)) begin xc = 2'd2; m_pend = 1'b0; end
    else xc = 2'd0;
    @(posedge clk);
    if (we) begin
      case (kd)
        2'd0: if (ix < N_BP) m_bpv[ix] = wd;
        2'd1: if (ix < N_BP) m_bpc[ix] = wd[13:0];
        2'd2: if (ix < N_WP) m_wpv[ix] = wd;
        default: if (ix < N_WP) m_wpc[ix] = wd[13:0];
      endcase
    end
    #1;
    checks++;
    if (bp_hit !== xb || wp_hit !== xw || evt_code !== xc || evt_valid !== (xc != 2'd0)) begin
      fails++;
      $display("FAIL %s: bp=%b wp=%b ev=%0d/%0d expected bp=%b wp=%b ev=%0d",
               tag, bp_hit, wp_hit, evt_valid, evt_code, xb, xw, xc);
    end
    wr_en = 1'b0; fetch_valid = 1'b0; data_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] kd, input logic [3:0] ix, input logic [AW-1:0] wd, input string tag);
    step(1'b1, kd, ix, wd, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic fet(input logic [AW-1:0] a, input logic p, input string tag);
    step(1'b0, 2'd0, 4'd0, '0, 1'b1, a, p, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic dat(input logic [AW-1:0] a, input logic w, input logic p, input string tag);
    step(1'b0, 2'd0, 4'd0, '0, 1'b0, '0, 1'b0, 1'b1, a, w, p, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N_BP; i++) begin m_bpv[i] = '0; m_bpc[i] = '0; end
    for (int j = 0; j < N_WP; j++) begin m_wpv[j] = '0; m_wpc[j] = '0; end
    m_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: cleared state, nothing fires
    checks++;
    if (bp_hit !== '0 || wp_hit !== '0 || evt_valid !== 1'b0) begin
      fails++; $display("FAIL R1: bp=%b wp=%b ev=%b expected zeros", bp_hit, wp_hit, evt_valid);
    end
    step(1'b0, 2'd0, 4'd0, '0, 1'b1, '0, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R1");
    // R10
    checks++;
    if (id_word !== {4'(N_WP-1), 4'(N_BP-1), 24'h0}) begin
      fails++; $display("FAIL R10: id=%h expected %h", id_word, {4'(N_WP-1), 4'(N_BP-1), 24'h0});
    end

    // R3: halfword breakpoint at 0x1000, lanes 0..1, both privileges
    wr(2'd0, 4'd0, 32'h1000, "R3");
    // R9: control write with coincident fetch uses old (disarmed) settings
    step(1'b1, 2'd1, 4'd0, 32'h0067, 1'b1, 32'h1000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9");
    fet(32'h1000, 1'b0, "R9");
    fet(32'h1001, 1'b1, "R3");
    fet(32'h1002, 1'b0, "R3");
    fet(32'h1004, 1'b0, "R3");
    // R2: disarm
    wr(2'd1, 4'd0, 32'h0, "R2");
    fet(32'h1000, 1'b0, "R2");
    // R7: privileged only
    wr(2'd1, 4'd0, 32'h01E3, "R7");
    fet(32'h1000, 1'b0, "R7");
    fet(32'h1000, 1'b1, "R7");
    // R4: inverted-match on slot 1
    wr(2'd0, 4'd1, 32'h2000, "R4");
    wr(2'd1, 4'd1, 32'h21E7, "R4");
    fet(32'h2000, 1'b0, "R4");
    fet(32'h2004, 1'b0, "R4");
    // R11: no fetch strobe, no data strobe
    step(1'b0, 2'd0, 4'd0, '0, 1'b0, 32'h2004, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R11");
    wr(2'd1, 4'd1, 32'h0, "R4");
    // R5: doubleword mask upper word only on wp0, word mask on wp1, same base
    wr(2'd2, 4'd0, 32'h3000, "R5");
    wr(2'd3, 4'd0, 32'h1E1F, "R5");
    wr(2'd2, 4'd1, 32'h3000, "R5");
    wr(2'd3, 4'd1, 32'h01FF, "R5");
    dat(32'h3004, 1'b0, 1'b0, "R5");
    dat(32'h3006, 1'b1, 1'b1, "R5");
    dat(32'h3002, 1'b0, 1'b0, "R5");
    dat(32'h3008, 1'b0, 1'b0, "R5");
    // R6: wp1 loads only
    wr(2'd3, 4'd1, 32'h01EF, "R6");
    dat(32'h3001, 1'b1, 1'b0, "R6");
    dat(32'h3001, 1'b0, 1'b0, "R6");
    // R8: simultaneous breakpoint and watchpoint
    step(1'b0, 2'd0, 4'd0, '0, 1'b1, 32'h1000, 1'b1, 1'b1, 32'h3004, 1'b0, 1'b0, "R8");
    step(1'b0, 2'd0, 4'd0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8");
    // R12: out-of-range index leaves registers untouched
    wr(2'd1, 4'(N_BP), 32'h2007, "R12");
    wr(2'd3, 4'd15, 32'h1FFF, "R12");
    fet(32'h5000, 1'b0, "R12");
    dat(32'h5000, 1'b1, 1'b0, "R12");

    // Random mix against the model (R3 R4 R5 R6 R7 R8)
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] pool [4];
      logic [AW-1:0] fa, da;
      int r;
      pool[0] = 32'h1000; pool[1] = 32'h1008; pool[2] = 32'h2000; pool[3] = 32'h1004;
      r = $urandom_range(0, 9);
      fa = pool[$urandom_range(0, 3)] | 32'($urandom_range(0, 7));
      da = pool[$urandom_range(0, 3)] | 32'($urandom_range(0, 7));
      if (r < 3) begin
        logic [1:0] kd;
        kd = 2'($urandom_range(0, 3));
        if (kd[0]) wr(kd, 4'($urandom_range(0, 4)), 32'($urandom), "R8 random");
        else       wr(kd, 4'($urandom_range(0, 4)), pool[$urandom_range(0, 3)], "R8 random");
      end else begin
        step(1'b0, 2'd0, 4'd0, '0, 1'($urandom), fa, 1'($urandom),
             1'($urandom), da, 1'($urandom), 1'($urandom), "R5 random");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule